// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block sits between a clocked host and an asynchronous 16-bit static RAM that has separate active-low enables for its upper and lower byte. The host presents one request at a time: an address, write data, two byte-lane enables and a read/write select, qualified by a request/ready handshake. The block turns each request into the strobe sequence the memory expects. It returns read data with a one-cycle valid pulse.

Writes are controlled by write enable. Chip enable and the selected byte enables go low together with write enable. The write ends when write enable rises, and the other strobes stay low for one more cycle. Every timing minimum of the memory is a nanosecond parameter. Each one is turned into a whole number of clock cycles by dividing by the clock period and rounding up, with a floor of one cycle. The data bus is split into an output, an input and a drive-enable. The block keeps its drivers off while the memory may still be driving, and always while output enable is low.

Top module: `sram_lane_ctrl`

## Requirements
- R1: Each timing phase lasts ceil(t_ns / CLK_NS) cycles and never fewer than 1. The write-enable low phase lasts exactly max(pulse width, chip-enable-to-end, address-to-end, lane-valid-to-end, bus-release + data-setup) cycles.
- R2: During a write, chip enable, the selected byte enables and write enable are low together. Write enable rises while chip enable and the selected byte enables are still low.
- R3: Write enable stays low for the full write-enable low phase of R1 on every write.
- R4: The data drivers stay off for the first ceil(bus-release) cycles after write enable falls. They are on for at least ceil(data-setup) cycles before write enable rises, and they are still on in the cycle when write enable rises.
- R5: The memory address does not change while write enable is low.
- R6: During a read, write enable is high and chip enable, output enable and the selected byte enables are low from the first strobe cycle. The data drivers are never on while output enable is low.
- R7: Read data is sampled on the clock edge that ends ceil(read-access) strobe cycles. rvalid is high for exactly one cycle, which is cycle ceil(read-access)+1 after the accepting edge. A lane whose enable is clear reads as zero.
- R8: host_be[1] set drives mem_ub_n low and selects bits 15:8. host_be[0] set drives mem_lb_n low and selects bits 7:0. Only enabled lanes are written.
- R9: A request with host_be = 2'b00 is accepted with no strobe activity and does not change memory. A read of this kind returns rvalid with zero data in the first cycle after acceptance.
- R10: host_ready goes low at the accepting edge and stays low for at least ceil(write-cycle) cycles. Requests made while host_ready is low are ignored.
- R11: While and after reset: host_ready is 1, all memory strobes are high, mem_dq_oe is 0 and host_rvalid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Request strobe |
| host_ready | output | 1 | Block can accept a request |
| host_addr | input | ADDR_W | Word address |
| host_wdata | input | 16 | Write data |
| host_be | input | 2 | Lane enables, bit 1 upper, bit 0 lower |
| host_wr | input | 1 | 1 write, 0 read |
| host_rdata | output | 16 | Read data, disabled lanes zero |
| host_rvalid | output | 1 | One-cycle read data valid |
| mem_addr | output | ADDR_W | Memory address |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_ub_n | output | 1 | Upper byte enable, active low |
| mem_lb_n | output | 1 | Lower byte enable, active low |
| mem_dq_out | output | 16 | Data driven to memory |
| mem_dq_oe | output | 1 | Data driver enable |
| mem_dq_in | input | 16 | Data from memory |

## Verification
The embedded assertions check the strobe relations on every cycle. These are: strobes still held when write enable rises, the quiet bus right after write enable falls, drivers on before the rise, no driving under output enable, a stable address while write enable is low, ready dropping after acceptance, single-cycle rvalid, and quiet null requests. Only the bench scenarios can show the rest. That covers the exact phase lengths and read latency, which lanes end up written, masking of read data, that requests made while busy are ignored, and that null writes leave memory unchanged. A behavioural memory model shows these by holding read data invalid until the access time has elapsed and by returning junk on disabled lanes.

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl #(
  parameter int ADDR_W    = 17,
  parameter int CLK_NS    = 10,
  parameter int T_WC_NS   = 55,
  parameter int T_PWE_NS  = 45,
  parameter int T_SCE_NS  = 50,
  parameter int T_AW_NS   = 50,
  parameter int T_PWB_NS  = 45,
  parameter int T_SD_NS   = 25,
  parameter int T_HZWE_NS = 30,
  parameter int T_AA_NS   = 55
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req,
  output logic              host_ready,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [15:0]       host_wdata,
  input  logic [1:0]        host_be,
  input  logic              host_wr,
  output logic [15:0]       host_rdata,
  output logic              host_rvalid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic              mem_ub_n,
  output logic              mem_lb_n,
  output logic [15:0]       mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [15:0]       mem_dq_in
);

  function automatic int cyc(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int LANE_W = 8;
  localparam int N_WC   = cyc(T_WC_NS);
  localparam int N_HZ   = cyc(T_HZWE_NS);
  localparam int N_SD   = cyc(T_SD_NS);
  localparam int N_AA   = cyc(T_AA_NS);
  localparam int N_WLOW = max2(max2(cyc(T_PWE_NS), cyc(T_SCE_NS)),
                               max2(max2(cyc(T_AW_NS), cyc(T_PWB_NS)), N_HZ + N_SD));
  localparam int N_MAX  = max2(max2(N_WC, N_WLOW), N_AA) + 2;
  localparam int CW     = $clog2(N_MAX + 1) + 1;

  typedef enum logic [2:0] {S_IDLE, S_WR, S_WEND, S_RD, S_WAIT} st_t;

  st_t               st;
  logic [CW-1:0]     ph, tot;
  logic [ADDR_W-1:0] a_r;
  logic [15:0]       d_r;
  logic [1:0]        be_r;
  logic              accept;

  assign accept     = host_req && (st == S_IDLE);
  assign host_ready = (st == S_IDLE);
  assign mem_addr   = a_r;
  assign mem_dq_out = d_r;
  assign mem_ce_n   = !(st == S_WR || st == S_WEND || st == S_RD);
  assign mem_we_n   = (st != S_WR);
  assign mem_oe_n   = (st != S_RD);
  assign mem_ub_n   = mem_ce_n || !be_r[1];
  assign mem_lb_n   = mem_ce_n || !be_r[0];
  assign mem_dq_oe  = (st == S_WR && ph >= CW'(N_HZ)) || (st == S_WEND);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      ph          <= '0;
      tot         <= '0;
      a_r         <= '0;
      d_r         <= '0;
      be_r        <= '0;
      host_rdata  <= '0;
      host_rvalid <= 1'b0;
    end else begin
      host_rvalid <= 1'b0;
      tot         <= accept ? '0 : (st != S_IDLE) ? tot + 1'b1 : tot;
      case (st)
        S_IDLE: if (accept) begin
          a_r  <= host_addr;
          d_r  <= host_wdata;
          be_r <= host_be;
          ph   <= '0;
          if (host_be == 2'b00) begin
            st <= S_WAIT;
            if (!host_wr) begin
              host_rvalid <= 1'b1;
              host_rdata  <= '0;
            end
          end else begin
            st <= host_wr ? S_WR : S_RD;
          end
        end
        S_WR: begin
          ph <= ph + 1'b1;
          if (ph == CW'(N_WLOW - 1)) st <= S_WEND;
        end
        S_WEND: st <= S_WAIT;
        S_RD: begin
          ph <= ph + 1'b1;
          if (ph == CW'(N_AA - 1)) begin
            host_rdata  <= mem_dq_in & {{LANE_W{be_r[1]}}, {LANE_W{be_r[0]}}};
            host_rvalid <= 1'b1;
            st          <= S_WAIT;
          end
        end
        S_WAIT: if (tot >= CW'(N_WC - 1)) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  p_strobes_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> !mem_ce_n && (!mem_ub_n || !mem_lb_n));
  p_quiet_after_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> !mem_dq_oe);
  p_driven_at_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> $past(mem_dq_oe) && mem_dq_oe);
  p_addr_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_addr));
  p_no_contention_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_dq_oe && mem_we_n);
  p_rvalid_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    host_rvalid |=> !host_rvalid);
  p_null_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && host_ready && host_be == 2'b00) |=> mem_ce_n);
  p_busy_after_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && host_ready) |=> !host_ready);

endmodule

// File: tb/sram_lane_ctrl_tb.sv
module sram_lane_ctrl_tb;
  localparam int CLK_NS = 10;
  localparam int AW     = 17;

  function automatic int cyc(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int E_WC   = cyc(55);
  localparam int E_HZ   = cyc(30);
  localparam int E_SD   = cyc(25);
  localparam int E_AA   = cyc(55);
  localparam int E_WLOW = 6;

  logic clk = 0, rst_n = 0;
  logic host_req = 0, host_wr = 0;
  logic [AW-1:0] host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic [1:0] host_be = '0;
  logic host_ready, host_rvalid;
  logic [15:0] host_rdata;
  logic [AW-1:0] mem_addr;
  logic mem_ce_n, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n, mem_dq_oe;
  logic [15:0] mem_dq_out, mem_dq_in;

  always #5 clk = ~clk;

  sram_lane_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_ready(host_ready),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_be(host_be), .host_wr(host_wr),
    .host_rdata(host_rdata), .host_rvalid(host_rvalid), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_ub_n(mem_ub_n),
    .mem_lb_n(mem_lb_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in));

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural memory
  logic [15:0] mem [0:63];
  int rd_age = 0;
  logic reading;
  assign reading = !mem_ce_n && !mem_oe_n && mem_we_n;
  always @(posedge clk) rd_age <= reading ? rd_age + 1 : 0;
  always_comb begin
    if (reading && rd_age >= E_AA - 1)
      mem_dq_in = {mem_ub_n ? 8'hA5 : mem[mem_addr[5:0]][15:8],
                   mem_lb_n ? 8'hA5 : mem[mem_addr[5:0]][7:0]};
    else
      mem_dq_in = 16'h5A5A;
  end

  // strobe monitor
  int welo = 0, drv = 0, strobe_cnt = 0;
  bit prev_we_lo = 0;
  logic [AW-1:0] prev_addr = '0;
  logic [15:0] last_dq = '0;
  logic [1:0] exp_be = '0;

  always @(negedge clk) if (rst_n) begin
    if (!mem_ce_n) strobe_cnt++;
    if (!mem_we_n) begin
      if (prev_we_lo && mem_addr != prev_addr) chk(0, "R5 addr moved", int'(mem_addr), int'(prev_addr));
      if (mem_dq_oe && welo < E_HZ) chk(0, "R4 early drive", welo, E_HZ);
      if (mem_dq_oe) drv++;
      if (mem_ce_n || (mem_ub_n && mem_lb_n)) chk(0, "R2 strobes apart", 0, 1);
      welo++;
      last_dq = mem_dq_out;
    end else if (prev_we_lo) begin
      chk(welo == E_WLOW, "R3 R1 we low length", welo, E_WLOW);
      chk(drv >= E_SD, "R4 setup", drv, E_SD);
      chk(mem_dq_oe, "R4 hold", mem_dq_oe, 1);
      chk(!mem_ce_n && {!mem_ub_n, !mem_lb_n} == exp_be, "R2 R8 strobes at rise",
          {30'd0, !mem_ub_n, !mem_lb_n}, {30'd0, exp_be});
      if (!mem_ub_n) mem[mem_addr[5:0]][15:8] = last_dq[15:8];
      if (!mem_lb_n) mem[mem_addr[5:0]][7:0]  = last_dq[7:0];
      welo = 0;
      drv = 0;
    end
    if (!mem_oe_n && (mem_dq_oe || !mem_we_n)) chk(0, "R6 contention", int'(mem_dq_oe), 0);
    prev_we_lo = !mem_we_n;
    prev_addr  = mem_addr;
  end

  task automatic issue(input logic [AW-1:0] a, input logic [15:0] d, input logic [1:0] be,
                       input logic wr, output int busy, output int rv_at, output logic [15:0] rd);
    int n;
    @(negedge clk);
    while (!host_ready) @(negedge clk);
    host_req = 1; host_addr = a; host_wdata = d; host_be = be; host_wr = wr;
    if (wr) exp_be = be;
    @(posedge clk);
    @(negedge clk);
    host_req = 0;
    busy = 0; rv_at = -1; rd = '0; n = 1;
    forever begin
      if (host_rvalid) begin rv_at = n; rd = host_rdata; end
      if (host_ready) break;
      busy++;
      @(negedge clk);
      n++;
    end
  endtask

  task automatic t_reset();
    chk(host_ready == 1, "R11 ready", host_ready, 1);
    chk({mem_ce_n, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n} == 5'h1F, "R11 strobes",
        {mem_ce_n, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n}, 5'h1F);
    chk(!mem_dq_oe && !host_rvalid, "R11 drive/rvalid", {mem_dq_oe, host_rvalid}, 0);
  endtask

  task automatic t_full_rw();
    int b, r; logic [15:0] d;
    issue(17'h1_0003, 16'hC3A1, 2'b11, 1, b, r, d);
    chk(b >= E_WC, "R10 write busy", b, E_WC);
    issue(17'h1_0003, 16'h0, 2'b11, 0, b, r, d);
    chk(r == E_AA + 1, "R7 R1 read latency", r, E_AA + 1);
    chk(d == 16'hC3A1, "R6 R7 read data", d, 16'hC3A1);
    chk(b >= E_WC, "R10 read busy", b, E_WC);
  endtask

  task automatic t_lanes();
    int b, r; logic [15:0] d;
    issue(17'h0_0007, 16'h1234, 2'b11, 1, b, r, d);
    issue(17'h0_0007, 16'hBEEF, 2'b10, 1, b, r, d);
    issue(17'h0_0007, 16'h0, 2'b11, 0, b, r, d);
    chk(d == 16'hBE34, "R8 upper lane write", d, 16'hBE34);
    issue(17'h0_0007, 16'h5566, 2'b01, 1, b, r, d);
    issue(17'h0_0007, 16'h0, 2'b11, 0, b, r, d);
    chk(d == 16'hBE66, "R8 lower lane write", d, 16'hBE66);
    issue(17'h0_0007, 16'h0, 2'b01, 0, b, r, d);
    chk(d == 16'h0066, "R7 upper masked", d, 16'h0066);
    issue(17'h0_0007, 16'h0, 2'b10, 0, b, r, d);
    chk(d == 16'hBE00, "R7 lower masked", d, 16'hBE00);
  endtask

  task automatic t_null();
    int b, r; logic [15:0] d;
    issue(17'h0_0009, 16'h7777, 2'b11, 1, b, r, d);
    strobe_cnt = 0;
    issue(17'h0_0009, 16'hDEAD, 2'b00, 1, b, r, d);
    chk(strobe_cnt == 0, "R9 null write quiet", strobe_cnt, 0);
    issue(17'h0_0009, 16'h0, 2'b00, 0, b, r, d);
    chk(strobe_cnt == 0, "R9 null read quiet", strobe_cnt, 0);
    chk(r == 1 && d == 16'h0, "R9 null read result", r, 1);
    issue(17'h0_0009, 16'h0, 2'b11, 0, b, r, d);
    chk(d == 16'h7777, "R9 memory unchanged", d, 16'h7777);
  endtask

  task automatic t_busy_ignore();
    int b, r; logic [15:0] d;
    issue(17'h0_000B, 16'h1111, 2'b11, 1, b, r, d);
    @(negedge clk);
    while (!host_ready) @(negedge clk);
    host_req = 1; host_addr = 17'h0_000A; host_wdata = 16'h2222; host_be = 2'b11; host_wr = 1;
    exp_be = 2'b11;
    @(posedge clk);
    @(negedge clk);
    host_addr = 17'h0_000C; host_wdata = 16'h9999;
    while (!host_ready) @(negedge clk);
    host_req = 0;
    issue(17'h0_000C, 16'h0, 2'b11, 0, b, r, d);
    chk(d == 16'h0000, "R10 busy request ignored", d, 0);
    issue(17'h0_000A, 16'h0, 2'b11, 0, b, r, d);
    chk(d == 16'h2222, "R10 accepted write", d, 16'h2222);
  endtask

  bit timeout = 0;
  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 16'h0;
    fork
      begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_full_rw();
        t_lanes();
        t_null();
        t_busy_ignore();
      end
      begin
        repeat (20000) @(posedge clk);
        timeout = 1;
      end
    join_any
    if (timeout) chk(0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule